// File: doc/BRIEF.md
# LIN Frame Responder

This block is the frame-level half of a LIN slave node. A UART running at the bus bit rate feeds it a one-cycle strobe whenever a break field has been seen and a byte strobe with every received character. The responder checks the sync character and decodes the protected identifier. Depending on that identifier, it either collects a fixed-length data field and tests its checksum, or it drives a fixed-length response (plus checksum) out through a byte-wide valid/acknowledge transmit port.

The machine has seven states: `ST_IDLE`, `ST_SYNC`, `ST_PID`, `ST_RXD`, `ST_RXC`, `ST_TXD` and `ST_TXC`. A break moves any state to `ST_SYNC` (arm). In `ST_SYNC` a 0x55 character leads to `ST_PID` (sync_ok), and any other character leads to `ST_IDLE` (sync_bad). In `ST_PID` the receive identifier leads to `ST_RXD` (go_rx), the transmit identifier leads to `ST_TXD` (go_tx), and any other value leads to `ST_IDLE` (pid_bad). The last data byte moves `ST_RXD` to `ST_RXC` (rx_last). The checksum character moves `ST_RXC` to `ST_IDLE` (rx_end). The last acknowledged data byte moves `ST_TXD` to `ST_TXC` (tx_last). The acknowledged checksum moves `ST_TXC` to `ST_IDLE` (tx_end). `ST_IDLE` stays where it is until a break arrives.

The checksum is an 8-bit sum with end-around carry over the identifier and the data bytes, then inverted. The response bytes come from a small register file with a write port.

Top module: `lin_frame_responder`

## Requirements
- R1: After reset the machine is in `ST_IDLE`. `tx_vld_o`, all five flag outputs and `rx_data_o` are 0.
- R2: `brk_i` moves every state to `ST_SYNC` at the next edge and aborts any frame in progress, so `tx_vld_o` is 0 in the following cycle. A byte strobe in the same cycle as `brk_i` is dropped.
- R3: In `ST_SYNC`, the character 0x55 advances to `ST_PID`. Any other character raises `sync_err_o` for one cycle in the cycle after the strobe, and the machine goes to `ST_IDLE`.
- R4: In `ST_IDLE`, byte strobes are ignored: no flag rises and no transmission starts until a break arrives.
- R5: In `ST_PID`, the value `RX_PID` (default 0xAD) selects receive and `TX_PID` (default 0x3C) selects transmit. Any other value raises `pid_err_o` for one cycle and the machine goes to `ST_IDLE`.
- R6: A receive frame takes `RX_LEN` (default 3) data bytes. Byte k (k counted from 0) lands in `rx_data_o[8k+7:8k]` in the cycle after its strobe. The next strobe after the data bytes is the checksum.
- R7: The checksum is the bitwise inverse of the 8-bit end-around-carry sum of the identifier and the data bytes (0xAD,0x01,0x02,0x03 gives 0x4C). On receive, a match pulses `frame_ok_o` and a mismatch pulses `csum_err_o`, each for one cycle in the cycle after the checksum strobe. `rx_data_o` keeps its bytes either way.
- R8: From the cycle after a transmit identifier, `tx_vld_o` is high. `tx_byte_o` shows register entries 0 to `TX_LEN-1` (default 2) and then the checksum. The port advances only at edges where `tx_ack_i` is high, and it holds the byte while the acknowledge is low.
- R9: `tx_done_o` pulses for one cycle after the checksum is acknowledged, and `tx_vld_o` returns to 0 in that cycle.
- R10: `resp_we_i` writes `resp_wdata_i` into entry `resp_addr_i` at the clock edge. A later response sends the written value.
- R11: After the last byte of a frame, the machine ignores every character until the next break.
- R12: While transmitting, received byte strobes (the bus echo) have no effect on the transmitted bytes or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| brk_i | input | 1 | Break detected strobe |
| rx_vld_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_vld_o | output | 1 | Transmit byte request |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_ack_i | input | 1 | Transmitter accepts the byte |
| resp_we_i | input | 1 | Response register write enable |
| resp_addr_i | input | RESP_AW | Response register index |
| resp_wdata_i | input | 8 | Response register write data |
| rx_data_o | output | RX_LEN*8 | Received data field |
| frame_ok_o | output | 1 | Received frame with good checksum |
| csum_err_o | output | 1 | Received frame with bad checksum |
| sync_err_o | output | 1 | Bad sync character |
| pid_err_o | output | 1 | Unknown identifier |
| tx_done_o | output | 1 | Response fully sent |

## Verification
The collision that matters most is a break and a byte strobe arriving in the same cycle. The bench also drives a break while a response is in flight with the acknowledge low. The break must win in both cases: the byte is dropped, and `tx_vld_o` falls at once. A second overlap is the echo strobe arriving during a transmit acknowledge; the echo must leave the sent bytes untouched. A behavioural model held in queues predicts every output on every clock, so the bench judges each of these collisions by the exact outputs that follow it.

// File: rtl/lin_rsp_pkg.sv
package lin_rsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PID,
        ST_RXD,
        ST_RXC,
        ST_TXD,
        ST_TXC
    } lin_st_e;

    localparam logic [7:0] SYNC_CHAR = 8'h55;

    // one step of an 8-bit sum whose carry is folded back into bit 0
    function automatic logic [7:0] fold_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

endpackage

// File: rtl/lin_csum_acc.sv
module lin_csum_acc
    import lin_rsp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ld_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic [7:0] sum_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sum_o <= 8'h00;
        end else if (ld_i) begin
            sum_o <= byte_i;
        end else if (add_i) begin
            sum_o <= fold_add(sum_o, byte_i);
        end
    end

    // R7: a load seeds the running sum with the identifier
    p_seed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> sum_o == $past(byte_i));

endmodule

// File: rtl/lin_resp_regs.sv
module lin_resp_regs #(
    parameter int DEPTH = 2,
    parameter int AW    = 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [7:0]    wd_i,
    input  logic [AW-1:0] ra_i,
    output logic [7:0]    rd_o
);

    logic [7:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mem_q[i] <= 8'h00;
            end else if (we_i && (int'(wa_i) == i)) begin
                mem_q[i] <= wd_i;
            end
        end
    end

    always_comb begin
        rd_o = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(ra_i) == i) rd_o = mem_q[i];
        end
    end

endmodule

// File: rtl/lin_frame_responder.sv
module lin_frame_responder
    import lin_rsp_pkg::*;
#(
    parameter logic [7:0] RX_PID = 8'hAD,
    parameter logic [7:0] TX_PID = 8'h3C,
    parameter int         RX_LEN = 3,
    parameter int         TX_LEN = 2,
    localparam int        RESP_AW = (TX_LEN > 1) ? $clog2(TX_LEN) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                brk_i,
    input  logic                rx_vld_i,
    input  logic [7:0]          rx_byte_i,
    output logic                tx_vld_o,
    output logic [7:0]          tx_byte_o,
    input  logic                tx_ack_i,
    input  logic                resp_we_i,
    input  logic [RESP_AW-1:0]  resp_addr_i,
    input  logic [7:0]          resp_wdata_i,
    output logic [RX_LEN*8-1:0] rx_data_o,
    output logic                frame_ok_o,
    output logic                csum_err_o,
    output logic                sync_err_o,
    output logic                pid_err_o,
    output logic                tx_done_o
);

    localparam int MAXLEN = (RX_LEN > TX_LEN) ? RX_LEN : TX_LEN;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] RX_LAST = CW'(RX_LEN - 1);
    localparam logic [CW-1:0] TX_LAST = CW'(TX_LEN - 1);

    lin_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          cnt_clr, cnt_inc, cap;
    logic          acc_ld, acc_add;
    logic [7:0]    acc_byte, sum, rd_byte;
    logic          f_ok, f_err, f_sync, f_pid, f_done;

    lin_resp_regs #(.DEPTH(TX_LEN), .AW(RESP_AW)) u_regs (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .we_i  (resp_we_i),
        .wa_i  (resp_addr_i),
        .wd_i  (resp_wdata_i),
        .ra_i  (cnt_q[RESP_AW-1:0]),
        .rd_o  (rd_byte)
    );

    assign acc_byte = (st_q == ST_TXD) ? rd_byte : rx_byte_i;

    lin_csum_acc u_acc (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ld_i  (acc_ld),
        .add_i (acc_add),
        .byte_i(acc_byte),
        .sum_o (sum)
    );

    assign tx_vld_o  = (st_q == ST_TXD) || (st_q == ST_TXC);
    assign tx_byte_o = (st_q == ST_TXC) ? ~sum : rd_byte;

    // next state and control
    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        cap     = 1'b0;
        acc_ld  = 1'b0;
        acc_add = 1'b0;
        f_ok    = 1'b0;
        f_err   = 1'b0;
        f_sync  = 1'b0;
        f_pid   = 1'b0;
        f_done  = 1'b0;
        if (brk_i) begin
            st_d    = ST_SYNC;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_SYNC: if (rx_vld_i) begin
                    if (rx_byte_i == SYNC_CHAR) begin
                        st_d = ST_PID;
                    end else begin
                        st_d   = ST_IDLE;
                        f_sync = 1'b1;
                    end
                end
                ST_PID: if (rx_vld_i) begin
                    if (rx_byte_i == RX_PID) begin
                        st_d    = ST_RXD;
                        acc_ld  = 1'b1;
                        cnt_clr = 1'b1;
                    end else if (rx_byte_i == TX_PID) begin
                        st_d    = ST_TXD;
                        acc_ld  = 1'b1;
                        cnt_clr = 1'b1;
                    end else begin
                        st_d  = ST_IDLE;
                        f_pid = 1'b1;
                    end
                end
                ST_RXD: if (rx_vld_i) begin
                    cap     = 1'b1;
                    acc_add = 1'b1;
                    cnt_inc = 1'b1;
                    if (cnt_q == RX_LAST) st_d = ST_RXC;
                end
                ST_RXC: if (rx_vld_i) begin
                    st_d = ST_IDLE;
                    if (rx_byte_i == ~sum) f_ok  = 1'b1;
                    else                   f_err = 1'b1;
                end
                ST_TXD: if (tx_ack_i) begin
                    acc_add = 1'b1;
                    cnt_inc = 1'b1;
                    if (cnt_q == TX_LAST) st_d = ST_TXC;
                end
                ST_TXC: if (tx_ack_i) begin
                    st_d   = ST_IDLE;
                    f_done = 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // counters, captured data and flags
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q      <= '0;
            rx_data_o  <= '0;
            frame_ok_o <= 1'b0;
            csum_err_o <= 1'b0;
            sync_err_o <= 1'b0;
            pid_err_o  <= 1'b0;
            tx_done_o  <= 1'b0;
        end else begin
            if (cnt_clr)      cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
            for (int i = 0; i < RX_LEN; i++) begin
                if (cap && (int'(cnt_q) == i)) rx_data_o[i*8 +: 8] <= rx_byte_i;
            end
            frame_ok_o <= f_ok;
            csum_err_o <= f_err;
            sync_err_o <= f_sync;
            pid_err_o  <= f_pid;
            tx_done_o  <= f_done;
        end
    end

    // R2: a break always removes the transmit request
    p_break_stops_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_i |=> !tx_vld_o);

    // R7: a received frame has a single verdict
    p_one_verdict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(frame_ok_o && csum_err_o));

    // R3: status pulses never overlap
    p_flags_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({frame_ok_o, csum_err_o, sync_err_o, pid_err_o, tx_done_o}));

    // R3: a sync error follows a received byte
    p_sync_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |-> $past(rx_vld_i));

    // R8: an unacknowledged byte is held steady
    p_tx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_vld_o && !tx_ack_i && !brk_i && !resp_we_i) |=> (tx_vld_o && $stable(tx_byte_o)));

    // R9: completion drops the request
    p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done_o |-> !tx_vld_o);

endmodule

// File: tb/lin_frame_responder_bench.sv
module lin_frame_responder_bench;

    localparam int RX_LEN = 3;
    localparam int TX_LEN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brk = 1'b0, vld = 1'b0, ack = 1'b1, we = 1'b0;
    logic [7:0] byt = 8'h00, wd = 8'h00;
    logic [0:0] wa = 1'b0;
    logic tx_vld, f_ok, f_err, f_sync, f_pid, f_done;
    logic [7:0] tx_byte;
    logic [RX_LEN*8-1:0] rx_data;

    int checks = 0, failures = 0, cyc = 0;
    int n_ok = 0, n_err = 0, n_sync = 0, n_pid = 0, n_done = 0;
    byte unsigned sent_q[$];

    always #2 clk = ~clk;

    lin_frame_responder u_lin_frame_responder (
        .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .rx_vld_i(vld), .rx_byte_i(byt),
        .tx_vld_o(tx_vld), .tx_byte_o(tx_byte), .tx_ack_i(ack),
        .resp_we_i(we), .resp_addr_i(wa), .resp_wdata_i(wd),
        .rx_data_o(rx_data), .frame_ok_o(f_ok), .csum_err_o(f_err),
        .sync_err_o(f_sync), .pid_err_o(f_pid), .tx_done_o(f_done)
    );

    // ---------------- behavioural reference ----------------
    int phase = 0;             // 0 idle 1 sync 2 pid 3 rx 4 rxcsum 5 tx
    int got = 0;
    byte unsigned frame_q[$];  // identifier and data seen so far
    byte unsigned txq[$];      // bytes still to send
    byte unsigned mregs[TX_LEN];
    logic [RX_LEN*8-1:0] m_rx = '0;
    logic m_ok = 0, m_err = 0, m_sync = 0, m_pid = 0, m_done = 0;

    function automatic byte unsigned lin_sum(byte unsigned q[$]);
        int s = 0;
        foreach (q[i]) begin
            s = s + q[i];
            if (s > 255) s = s - 255;
        end
        return byte'(~s);
    endfunction

    always @(posedge clk) begin
        m_ok = 0; m_err = 0; m_sync = 0; m_pid = 0; m_done = 0;
        if (!rst_n) begin
            phase = 0; m_rx = '0; txq.delete();
            foreach (mregs[i]) mregs[i] = 0;
        end else begin
            if (brk) begin
                phase = 1; txq.delete();
            end else if (phase == 1 && vld) begin
                if (byt == 8'h55) phase = 2; else begin m_sync = 1; phase = 0; end
            end else if (phase == 2 && vld) begin
                frame_q.delete(); frame_q.push_back(byt);
                if (byt == 8'hAD) begin phase = 3; got = 0; end
                else if (byt == 8'h3C) begin
                    for (int i = 0; i < TX_LEN; i++) begin
                        frame_q.push_back(mregs[i]); txq.push_back(mregs[i]);
                    end
                    txq.push_back(lin_sum(frame_q));
                    phase = 5;
                end else begin m_pid = 1; phase = 0; end
            end else if (phase == 3 && vld) begin
                m_rx[got*8 +: 8] = byt; frame_q.push_back(byt); got++;
                if (got == RX_LEN) phase = 4;
            end else if (phase == 4 && vld) begin
                if (byt == lin_sum(frame_q)) m_ok = 1; else m_err = 1;
                phase = 0;
            end else if (phase == 5 && ack) begin
                void'(txq.pop_front());
                if (txq.size() == 0) begin m_done = 1; phase = 0; end
            end
            if (we) mregs[wa] = wd;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 tx_vld", tx_vld, (phase == 5));
            if (phase == 5 && txq.size() > 0) check("R8 tx_byte", tx_byte, txq[0]);
            check("R6 rx_data", rx_data, m_rx);
            check("R7 frame_ok", f_ok, m_ok);
            check("R7 csum_err", f_err, m_err);
            check("R3 sync_err", f_sync, m_sync);
            check("R5 pid_err", f_pid, m_pid);
            check("R9 tx_done", f_done, m_done);
            if (tx_vld && ack) sent_q.push_back(tx_byte);
            n_ok += f_ok; n_err += f_err; n_sync += f_sync; n_pid += f_pid; n_done += f_done;
        end
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(logic b, logic v, logic [7:0] d);
        @(negedge clk); brk = b; vld = v; byt = d;
        @(negedge clk); brk = 0; vld = 0;
    endtask
    task automatic rxb(logic [7:0] d); put(0, 1, d); endtask
    task automatic brk_sync(); put(1, 0, 0); rxb(8'h55); endtask
    task automatic wr(int a, logic [7:0] d);
        @(negedge clk); we = 1; wa = 1'(a); wd = d;
        @(negedge clk); we = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", {tx_vld, f_ok, f_err, f_sync, f_pid, f_done}, 0);
        check("R1 reset rx_data", rx_data, 0);
        rst_n = 1;
        idle(2);

        // R6 R7: good receive frame
        brk_sync(); rxb(8'hAD); rxb(8'h01); rxb(8'h02); rxb(8'h03); rxb(8'h4C);
        idle(2);
        check("R6 rx bytes in order", rx_data, 24'h030201);
        check("R7 good checksum seen", n_ok, 1);

        // R7: bad checksum, data kept
        brk_sync(); rxb(8'hAD); rxb(8'h10); rxb(8'h20); rxb(8'h30); rxb(8'h00);
        idle(2);
        check("R7 bad checksum seen", n_err, 1);
        check("R7 data kept after error", rx_data, 24'h302010);

        // R7: end-around carry, sum stays 0xAD, checksum 0x52
        brk_sync(); rxb(8'hAD); rxb(8'hFF); rxb(8'hFF); rxb(8'hFF); rxb(8'h52);
        idle(2);
        check("R7 carry wrap checksum", n_ok, 2);

        // R11: characters after the checksum are ignored
        rxb(8'h55); rxb(8'hAD); rxb(8'h3C); rxb(8'h00);
        idle(2);
        check("R11 no flags after frame", n_ok + n_err + n_sync + n_pid + n_done, 2 + 1);

        // R3 R4: bad sync, then idle ignores bytes
        put(1, 0, 0); rxb(8'h54);
        rxb(8'h55); rxb(8'hAD); rxb(8'h3C);
        idle(2);
        check("R3 sync error count", n_sync, 1);
        check("R4 idle ignores bytes", tx_vld, 0);

        // R5: unknown identifier
        brk_sync(); rxb(8'h77); rxb(8'h01);
        idle(2);
        check("R5 pid error count", n_pid, 1);

        // R10 R8 R9: transmit with stall and echo (R12)
        wr(0, 8'h11); wr(1, 8'h22);
        @(negedge clk); ack = 0;
        brk_sync(); rxb(8'h3C);
        idle(3);
        check("R8 held during stall", tx_byte, 8'h11);
        sent_q.delete();
        @(negedge clk); ack = 1; vld = 1; byt = 8'h11;   // echo with ack, R12
        @(negedge clk); vld = 0;
        idle(4);
        check("R9 tx done count", n_done, 1);
        check("R8 bytes sent", sent_q.size(), 3);
        if (sent_q.size() == 3) begin
            check("R10 first reg byte", sent_q[0], 8'h11);
            check("R12 second byte unaffected by echo", sent_q[1], 8'h22);
            check("R8 tx checksum", sent_q[2], 8'h90);
        end

        // R2: break during a stalled response
        @(negedge clk); ack = 0;
        brk_sync(); rxb(8'h3C);
        idle(2);
        check("R8 tx active before break", tx_vld, 1);
        put(1, 0, 0);
        check("R2 break aborts tx", tx_vld, 0);
        @(negedge clk); ack = 1;

        // R2: break and byte in the same cycle, byte dropped
        put(1, 1, 8'h54);
        rxb(8'h55); rxb(8'hAD); rxb(8'h01); rxb(8'h02); rxb(8'h03); rxb(8'h4C);
        idle(2);
        check("R2 colliding byte dropped", n_sync, 1);
        check("R2 frame after collision", n_ok, 3);

        idle(4);
        finish_run();
    end

endmodule